// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block orders the switching-on and switching-off of six supply rails (one switching converter, index 0, and five linear regulators, indices 1 to 5) in a power-management device. A hardware enable pin starts and stops the sequence. A supply-valid input and a thermal-trip input override it. Each rail has a 3-bit delay field and a software enable bit. The register file holds both and presents them as parallel inputs.

Time is counted in ticks of `TICK_CYCLES` clocks. One tick is the 128 µs slot period. On a rising enable edge, each rail is granted its turn after (field+1) ticks. On a falling edge, grants are withdrawn at the mirrored slot times, so the latest rail goes first. A collapse of the input supply clears everything at once. After a thermal trip clears, a rearm field selects one of three actions: restart with reloaded defaults, restart with the current settings, or stay off.

Top module: `rail_sequencer`

## Requirements
- R1: On a rising edge of `hw_en`, the clock edge that samples it counts as cycle 0. Rail i with delay field f = `delay_cfg[3i+2:3i]` has its grant set from cycle (f+1)×`TICK_CYCLES` onward, and not before that cycle.
- R2: Rails that share a delay field value turn on in the same clock cycle.
- R3: On a falling edge of `hw_en` (cycle 0), rail i loses its grant from cycle (8−f)×`TICK_CYCLES` onward. Rails with larger fields therefore turn off earlier.
- R4: `seq_done` is 0 from cycle 0 of a power-up until cycle 16×`TICK_CYCLES`, and 1 from then on. It is 1 in every cycle in which the registered enable is low.
- R5: `rail_on[i]` is 1 only while rail i holds a grant and `sw_en[i]` is 1. Changing `sw_en` switches that rail alone.
- R6: A rail that is on never discharges. A rail that is off discharges (`rail_dis`=1) in every phase except the settled on phase. In the settled on phase, its discharge equals `pulldown_cfg[i]`.
- R7: While `supply_ok` is 0, all rails are off at once, all discharges are 1, and the logic is held in reset. When the supply returns with `hw_en` high, a full power-up follows.
- R8: A `therm_trip` seen while any rail is sequencing or on turns every rail off at the next clock edge, with no staged order.
- R9: When the trip clears with `rearm_sel`=00, `reload_defaults` pulses high for exactly one cycle, at the edge where the trip is seen low. A full power-up restarts from that edge.
- R10: When the trip clears with `rearm_sel`=01, a full power-up restarts from that edge and `reload_defaults` stays 0.
- R11: With `rearm_sel`=10 or 11, all rails stay off after the trip clears and `seq_done` stays 0. Only a fall and a new rise of `hw_en` start a power-up.
- R12: A rising edge of `hw_en` during a power-down restarts the power-up timer from zero. Rails that have not yet dropped stay on.
- R13: After reset, all rails are off, all discharges are 1, `seq_done` is 1 and `reload_defaults` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Input supply above the lockout threshold; low holds the block in reset |
| hw_en | input | 1 | Hardware enable pin |
| therm_trip | input | 1 | Thermal shutdown condition |
| rearm_sel | input | 2 | Action after a thermal trip clears: 00 reload and restart, 01 restart, 1x stay off |
| delay_cfg | input | 18 | Per-rail 3-bit delay fields, rail i at bits 3i+2:3i |
| sw_en | input | 6 | Per-rail software enable |
| pulldown_cfg | input | 6 | Per-rail discharge setting used in the settled on phase |
| rail_on | output | 6 | Per-rail on control |
| rail_dis | output | 6 | Per-rail output discharge control |
| seq_done | output | 1 | Sequence-done sense bit |
| reload_defaults | output | 1 | One-cycle request to reload default register values |

## Verification
The bench builds the block with six rails, 3-bit fields, a 16-tick done point and `TICK_CYCLES`=4. This shrinks a full power-up to 64 cycles and a full power-down to 32. The short tick lets every cycle of many randomised sequences be compared against the slot arithmetic. It also brings into reach the edges at which grants, drops, the done bit and the rearm actions occur. These include a restart in the middle of a power-down, and thermal trips under each rearm code.

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int NUM_RAILS   = 6,
  parameter int FIELD_W     = 3,
  parameter int TICK_CYCLES = 128,
  parameter int DONE_TICKS  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         supply_ok,
  input  logic                         hw_en,
  input  logic                         therm_trip,
  input  logic [1:0]                   rearm_sel,
  input  logic [NUM_RAILS*FIELD_W-1:0] delay_cfg,
  input  logic [NUM_RAILS-1:0]         sw_en,
  input  logic [NUM_RAILS-1:0]         pulldown_cfg,
  output logic [NUM_RAILS-1:0]         rail_on,
  output logic [NUM_RAILS-1:0]         rail_dis,
  output logic                         seq_done,
  output logic                         reload_defaults
);
  localparam int SLOTS = 1 << FIELD_W;
  localparam int PW    = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam int CW    = $clog2(DONE_TICKS + 1);

  typedef enum logic [2:0] {S_OFF, S_UP, S_ON, S_DOWN, S_TSD, S_HOLD} state_t;

  state_t               state;
  logic                 en_q, done_q, reload_q;
  logic [PW-1:0]        pre;
  logic [CW-1:0]        cnt;
  logic [NUM_RAILS-1:0] grant_q, grant_hit, drop_hit;

  wire arst_n = rst_n & supply_ok;
  wire rise   = hw_en & ~en_q;
  wire fall   = ~hw_en & en_q;
  wire tick   = (pre == PW'(TICK_CYCLES - 1));

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_slot
    wire [CW-1:0] fld = CW'(delay_cfg[i*FIELD_W +: FIELD_W]);
    assign grant_hit[i] = (cnt >= fld);
    assign drop_hit[i]  = (cnt >= CW'(SLOTS - 1) - fld);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state    <= S_OFF;
      en_q     <= 1'b0;
      done_q   <= 1'b0;
      reload_q <= 1'b0;
      pre      <= '0;
      cnt      <= '0;
      grant_q  <= '0;
    end else begin
      en_q     <= hw_en;
      reload_q <= 1'b0;
      case (state)
        S_OFF: if (rise) begin
          state  <= S_UP;
          pre    <= '0;
          cnt    <= '0;
          done_q <= 1'b0;
        end
        S_UP, S_ON, S_DOWN: begin
          if (therm_trip) begin
            state   <= S_TSD;
            grant_q <= '0;
            done_q  <= 1'b0;
          end else if (state != S_DOWN && fall) begin
            state <= S_DOWN;
            pre   <= '0;
            cnt   <= '0;
          end else if (state == S_DOWN && rise) begin
            state  <= S_UP;
            pre    <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
          end else if (state != S_ON) begin
            pre <= tick ? '0 : pre + 1'b1;
            if (tick) begin
              cnt <= cnt + 1'b1;
              if (state == S_UP) begin
                grant_q <= grant_q | grant_hit;
                if (cnt == CW'(DONE_TICKS - 1)) begin
                  state  <= S_ON;
                  done_q <= 1'b1;
                end
              end else begin
                grant_q <= grant_q & ~drop_hit;
                if (cnt == CW'(SLOTS - 1)) state <= S_OFF;
              end
            end
          end
        end
        S_TSD: if (!therm_trip) begin
          reload_q <= (rearm_sel == 2'b00);
          if (!hw_en) state <= S_OFF;
          else if (!rearm_sel[1]) begin
            state  <= S_UP;
            pre    <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
          end else state <= S_HOLD;
        end
        S_HOLD: if (!hw_en) state <= S_OFF;
        default: state <= S_OFF;
      endcase
    end
  end

  assign rail_on         = grant_q & sw_en;
  assign rail_dis        = ~rail_on & ((state == S_ON) ? pulldown_cfg : {NUM_RAILS{1'b1}});
  assign seq_done        = ~en_q | done_q;
  assign reload_defaults = reload_q;
endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk #(
  parameter int NUM_RAILS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 supply_ok,
  input logic                 hw_en,
  input logic                 therm_trip,
  input logic [NUM_RAILS-1:0] sw_en,
  input logic [NUM_RAILS-1:0] rail_on,
  input logic [NUM_RAILS-1:0] rail_dis,
  input logic                 seq_done,
  input logic                 reload_defaults
);
  a_r7_uvlo_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (rail_on == '0 && rail_dis == '1));

  a_r8_trip_clears_rails: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    (therm_trip && rail_on != '0) |=> (rail_on == '0));

  a_r6_no_discharge_when_on: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    (rail_on & rail_dis) == '0);

  a_r5_sw_enable_gates: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    (rail_on & ~sw_en) == '0);

  a_r9_reload_single_cycle: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    reload_defaults |=> !reload_defaults);

  a_r4_done_while_enable_low: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    !$past(hw_en) |-> seq_done);
endmodule

bind rail_sequencer rail_sequencer_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hw_en(hw_en),
  .therm_trip(therm_trip), .sw_en(sw_en), .rail_on(rail_on),
  .rail_dis(rail_dis), .seq_done(seq_done), .reload_defaults(reload_defaults)
);

// File: tb/rail_sequencer_tb.sv
module rail_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 6;
  localparam int FW    = 3;
  localparam int TICK  = 4;
  localparam int DONE  = 16;
  localparam int SLOTS = 8;
  localparam int ON_C  = DONE * TICK + 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0, supply_ok = 1'b1, hw_en = 1'b0, therm_trip = 1'b0;
  logic [1:0] rearm_sel = 2'b00;
  logic [N*FW-1:0] delay_cfg;
  logic [N-1:0] sw_en = '1, pulldown_cfg = '0;
  logic [N-1:0] rail_on, rail_dis;
  logic seq_done, reload_defaults;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [N-1:0] grant = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_sequencer #(.NUM_RAILS(N), .FIELD_W(FW), .TICK_CYCLES(TICK), .DONE_TICKS(DONE)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hw_en(hw_en), .therm_trip(therm_trip),
    .rearm_sel(rearm_sel), .delay_cfg(delay_cfg), .sw_en(sw_en), .pulldown_cfg(pulldown_cfg),
    .rail_on(rail_on), .rail_dis(rail_dis), .seq_done(seq_done), .reload_defaults(reload_defaults)
  );

  function automatic int fld(int i);
    return int'(delay_cfg[i*FW +: FW]);
  endfunction

  function automatic int on_time(int i);
    return (fld(i) + 1) * TICK;
  endfunction

  function automatic int off_time(int i);
    return (SLOTS - fld(i)) * TICK;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // mode 0: power-up (R1/R2/R12), 1: power-down (R3), 2: held off after trip (R11)
  task automatic run_phase(int mode, int c0, int n, bit exp_rl, string tag);
    for (int c = c0; c < c0 + n; c++) begin
      logic [N-1:0] exp_on, exp_dis;
      bit in_on, exp_done;
      @(posedge clk); #1;
      for (int i = 0; i < N; i++) begin
        if (mode == 0 && c >= on_time(i)) grant[i] = 1'b1;
        if (mode == 1 && c >= off_time(i)) grant[i] = 1'b0;
        if (mode == 2) grant[i] = 1'b0;
      end
      exp_on   = grant & sw_en;
      in_on    = (mode == 0) && (c >= DONE * TICK);
      exp_dis  = ~exp_on & (in_on ? pulldown_cfg : '1);
      exp_done = (mode == 1) ? 1'b1 : in_on;
      check(tag, rail_on, exp_on);
      check("R6", rail_dis, exp_dis);
      check("R4", {5'b0, seq_done}, {5'b0, exp_done});
      check("R9", {5'b0, reload_defaults}, {5'b0, (exp_rl && c == c0)});
    end
  endtask

  task automatic power_up(string tag);
    @(negedge clk); hw_en = 1'b1;
    run_phase(0, 0, DONE * TICK + 3, 1'b0, tag);
  endtask

  task automatic power_down();
    @(negedge clk); hw_en = 1'b0;
    run_phase(1, 0, SLOTS * TICK + 3, 1'b0, "R3");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    delay_cfg = {3'b110, 3'b101, 3'b100, 3'b011, 3'b001, 3'b000};
    repeat (3) @(negedge clk);
    #1;
    // R13 reset state
    check("R13", rail_on, '0);
    check("R13", rail_dis, '1);
    check("R13", {5'b0, seq_done}, 6'd1);
    check("R13", {5'b0, reload_defaults}, 6'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 default slot order, then R3 reverse
    power_up("R1");
    power_down();

    // R2 shared slots
    delay_cfg = {3'b010, 3'b010, 3'b111, 3'b000, 3'b010, 3'b000};
    pulldown_cfg = 6'b101010;
    power_up("R2");
    power_down();

    // random configurations with R5 mid-run switching
    for (int t = 0; t < 6; t++) begin
      delay_cfg    = N*FW'($urandom);
      sw_en        = N'($urandom) | 6'b000001;
      pulldown_cfg = N'($urandom);
      power_up("R1");
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); sw_en = N'($urandom);
        run_phase(0, ON_C, 4, 1'b0, "R5");
      end
      power_down();
    end

    // R12 restart during power-down
    delay_cfg = {3'b111, 3'b000, 3'b101, 3'b010, 3'b001, 3'b110};
    sw_en = '1;
    power_up("R1");
    @(negedge clk); hw_en = 1'b0;
    run_phase(1, 0, 3 * TICK + 1, 1'b0, "R3");
    @(negedge clk); hw_en = 1'b1;
    run_phase(0, 0, DONE * TICK + 3, 1'b0, "R12");

    // R8 trip, R9 rearm 00
    rearm_sel = 2'b00;
    @(negedge clk); therm_trip = 1'b1;
    @(posedge clk); #1;
    grant = '0;
    check("R8", rail_on, '0);
    check("R8", {5'b0, seq_done}, 6'd0);
    @(negedge clk); therm_trip = 1'b0;
    run_phase(0, 0, DONE * TICK + 3, 1'b1, "R9");

    // R10 rearm 01
    rearm_sel = 2'b01;
    @(negedge clk); therm_trip = 1'b1;
    @(posedge clk); #1;
    grant = '0;
    check("R8", rail_on, '0);
    @(negedge clk); therm_trip = 1'b0;
    run_phase(0, 0, DONE * TICK + 3, 1'b0, "R10");

    // R11 rearm 10 and 11 stay off
    for (int r = 2; r < 4; r++) begin
      rearm_sel = 2'(r);
      @(negedge clk); therm_trip = 1'b1;
      @(posedge clk); #1;
      grant = '0;
      check("R8", rail_on, '0);
      @(negedge clk); therm_trip = 1'b0;
      run_phase(2, 0, 40, 1'b0, "R11");
      @(negedge clk); hw_en = 1'b0;
      run_phase(1, 0, 3, 1'b0, "R11");
      power_up("R11");
    end

    // R7 supply collapse and return
    @(negedge clk); supply_ok = 1'b0;
    #1;
    check("R7", rail_on, '0);
    check("R7", rail_dis, '1);
    repeat (3) @(negedge clk);
    #1;
    check("R7", rail_on, '0);
    grant = '0;
    @(negedge clk); supply_ok = 1'b1;
    run_phase(0, 0, DONE * TICK + 3, 1'b0, "R7");
    power_down();

    finish_run();
  end
endmodule